// File: doc/BRIEF.md
# Interrupt Priority and Service Core

This block arbitrates among eight interrupt lines on behalf of a processor. Each line is driven by one-cycle raise and drop events. A raise sets a line latch and a request bit. A drop clears both. Every cycle the core looks at the requests that are allowed by an enable mask. It takes the lowest-numbered one as the candidate, because line 0 carries the highest priority. It then compares that candidate against the lines already in service, and raises a registered interrupt flag only when no in-service line of equal or higher priority stands in the way.

When the processor pulses the acknowledge strobe while the flag is up, the core does four things. It registers a vector formed from a supplied base OR-ed with the chosen line number. It clears the request bit of that line if the line is edge-triggered. It marks the line in service unless automatic end-of-interrupt is selected. It then re-arbitrates. If no request remains at that moment, the acknowledge yields the spurious line number 7. End-of-interrupt commands release either the highest-priority in-service line or a named one. A special mask setting lets masked-off in-service lines stop blocking others.

Top module: `intr_prio_core`

## Requirements
- R1: While `rstN` is low, `irqOut`, `reqRegOut`, `svcRegOut` and `vectorOut` are all zero, and all line latches are cleared.
- R2: A `raiseStb` pulse on an unlatched line sets its bit in `reqRegOut` at that clock edge. If the line is enabled and not blocked, `irqOut` rises at the following edge.
- R3: The candidate is the lowest-numbered bit of `reqRegOut & enableMask`. A bit of `enableMask` equal to 1 enables its line, and disabled lines never cause `irqOut`.
- R4: No request is raised while the lowest set bit of the in-service view has a one-hot value less than or equal to the candidate's. This includes an in-service line equal to the candidate.
- R5: With `specialMask` high, the in-service view is `svcRegOut & enableMask`. In-service lines that are disabled then block nothing, and a view of zero blocks nothing.
- R6: An `ackStb` pulse while `irqOut` is high loads `vectorOut` with `vectorBase | line` at that edge and drops `irqOut` at that edge.
- R7: On acknowledge, the chosen line's request bit is cleared when its `levelSel` bit is 0 (edge mode). It is kept when its `levelSel` bit is 1 (level mode).
- R8: On acknowledge, the chosen line's in-service bit is set when `autoEoi` is 0. It is left unchanged when `autoEoi` is 1.
- R9: If `reqRegOut` is zero when an acknowledge is taken, `vectorOut` becomes `vectorBase | 7`. No request or in-service bit changes.
- R10: A raise on a line that is already latched has no effect, even when its request bit has been cleared by an acknowledge. A drop clears both the latch and the request bit.
- R11: An `eoiValid` pulse with `eoiSpecific` 0 clears the lowest set bit of `svcRegOut`. With `eoiSpecific` 1 it clears bit `eoiLine`.
- R12: Once high, `irqOut` stays high until an acknowledge, or until `reqRegOut` has been zero at a clock edge. An `ackStb` pulse while `irqOut` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| raiseStb | input | 8 | Per-line raise events |
| dropStb | input | 8 | Per-line drop events |
| enableMask | input | 8 | 1 enables the line |
| levelSel | input | 8 | 1 selects level mode for the line |
| autoEoi | input | 1 | Skip in-service marking on acknowledge |
| specialMask | input | 1 | Disabled in-service lines do not block |
| eoiValid | input | 1 | End-of-interrupt command strobe |
| eoiSpecific | input | 1 | 1 selects a specific end-of-interrupt |
| eoiLine | input | 3 | Line released by a specific end-of-interrupt |
| vectorBase | input | 8 | Base OR-ed into the vector |
| ackStb | input | 1 | Processor acknowledge strobe |
| irqOut | output | 1 | Registered interrupt request |
| vectorOut | output | 8 | Vector from the last acknowledge |
| reqRegOut | output | 8 | Request register |
| svcRegOut | output | 8 | In-service register |

## Verification
Each of the eight lines is raised alone and acknowledged. This separates vector formation, the edge-mode clearing of the request bit, in-service marking and the behaviour of repeated raises on every bit position. All 28 ordered pairs of lines are raised together. This checks that the lower number wins. It also checks that the loser stays held off until a non-specific end-of-interrupt releases it. Dedicated patterns then cover four more cases: a disabled line, special-mask unblocking against plain blocking, level-mode retention with and without automatic end-of-interrupt, and a drop just before acknowledge that yields the spurious vector.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  typedef struct packed {
    logic             loadVec;
    logic [IDX_W-1:0] vecLine;
    logic [LINES-1:0] reqClr;
    logic [LINES-1:0] svcSet;
    logic [LINES-1:0] svcClr;
  } ctrlStrb_t;

  function automatic logic [LINES-1:0] lowOneHot(input logic [LINES-1:0] x);
    return x & (~x + LINES'(1));
  endfunction

  function automatic logic [IDX_W-1:0] hotIndex(input logic [LINES-1:0] x);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (x[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import intr_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackStb,
  input  logic [LINES-1:0] enableMask,
  input  logic [LINES-1:0] levelSel,
  input  logic             autoEoi,
  input  logic             specialMask,
  input  logic             eoiValid,
  input  logic             eoiSpecific,
  input  logic [IDX_W-1:0] eoiLine,
  input  logic [LINES-1:0] reqReg,
  input  logic [LINES-1:0] svcReg,
  output logic             irqPend,
  output ctrlStrb_t        strb
);
  logic [LINES-1:0] candHot;
  logic [LINES-1:0] svcView;
  logic [LINES-1:0] svcLow;
  logic [LINES-1:0] pendHot;
  logic [IDX_W-1:0] pendLine;
  logic             candOk;
  logic             takeAck;
  logic             spurious;

  assign candHot  = lowOneHot(reqReg & enableMask);
  assign svcView  = specialMask ? (svcReg & enableMask) : svcReg;
  assign svcLow   = lowOneHot(svcView);
  assign candOk   = (candHot != '0) && !((svcLow != '0) && (svcLow <= candHot));
  assign takeAck  = ackStb && irqPend;
  assign spurious = (reqReg == '0);
  assign pendHot  = {{(LINES-1){1'b0}}, 1'b1} << pendLine;

  always_comb begin
    strb         = '0;
    strb.loadVec = takeAck;
    strb.vecLine = spurious ? '1 : pendLine;
    if (takeAck && !spurious) begin
      strb.reqClr = pendHot & ~levelSel;
      strb.svcSet = autoEoi ? '0 : pendHot;
    end
    if (eoiValid) begin
      strb.svcClr = eoiSpecific ? ({{(LINES-1){1'b0}}, 1'b1} << eoiLine)
                                : lowOneHot(svcReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend  <= 1'b0;
      pendLine <= '0;
    end else if (takeAck) begin
      irqPend  <= 1'b0;
    end else if (irqPend) begin
      if (reqReg == '0) irqPend <= 1'b0;
    end else if (candOk) begin
      irqPend  <= 1'b1;
      pendLine <= hotIndex(candHot);
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    irqPend && !ackStb && (reqReg != '0) |=> irqPend); // R12
  AST_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    irqPend && !ackStb && (reqReg == '0) |=> !irqPend); // R12
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !irqPend && ((reqReg & enableMask) == '0) |=> !irqPend); // R3
endmodule

// File: rtl/intr_prio_datapath.sv
module intr_prio_datapath
  import intr_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] raiseStb,
  input  logic [LINES-1:0] dropStb,
  input  logic [VEC_W-1:0] vectorBase,
  input  ctrlStrb_t        strb,
  output logic [LINES-1:0] reqReg,
  output logic [LINES-1:0] svcReg,
  output logic [VEC_W-1:0] vectorOut
);
  logic [LINES-1:0] lineLatch;
  logic [LINES-1:0] newRaise;

  assign newRaise = raiseStb & ~lineLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLatch <= '0;
      reqReg    <= '0;
      svcReg    <= '0;
      vectorOut <= '0;
    end else begin
      lineLatch <= (lineLatch | raiseStb) & ~dropStb;
      reqReg    <= ((reqReg & ~strb.reqClr) | newRaise) & ~dropStb;
      svcReg    <= (svcReg | strb.svcSet) & ~strb.svcClr;
      if (strb.loadVec) vectorOut <= vectorBase | VEC_W'(strb.vecLine);
    end
  end

  AST_SVC_SET_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.svcSet != '0) && (strb.svcClr == '0) |=> ((svcReg & $past(strb.svcSet)) != '0)); // R8
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dropStb != '0) |=> ((reqReg & $past(dropStb)) == '0)); // R10
endmodule

// File: rtl/intr_prio_core.sv
module intr_prio_core
  import intr_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] raiseStb,
  input  logic [LINES-1:0] dropStb,
  input  logic [LINES-1:0] enableMask,
  input  logic [LINES-1:0] levelSel,
  input  logic             autoEoi,
  input  logic             specialMask,
  input  logic             eoiValid,
  input  logic             eoiSpecific,
  input  logic [IDX_W-1:0] eoiLine,
  input  logic [VEC_W-1:0] vectorBase,
  input  logic             ackStb,
  output logic             irqOut,
  output logic [VEC_W-1:0] vectorOut,
  output logic [LINES-1:0] reqRegOut,
  output logic [LINES-1:0] svcRegOut
);
  ctrlStrb_t strb;

  intr_prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackStb(ackStb), .enableMask(enableMask),
    .levelSel(levelSel), .autoEoi(autoEoi), .specialMask(specialMask),
    .eoiValid(eoiValid), .eoiSpecific(eoiSpecific), .eoiLine(eoiLine),
    .reqReg(reqRegOut), .svcReg(svcRegOut), .irqPend(irqOut), .strb(strb)
  );

  intr_prio_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .raiseStb(raiseStb), .dropStb(dropStb),
    .vectorBase(vectorBase), .strb(strb), .reqReg(reqRegOut),
    .svcReg(svcRegOut), .vectorOut(vectorOut)
  );

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && irqOut |=> !irqOut); // R6
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && irqOut && (reqRegOut == '0) |=> (vectorOut[IDX_W-1:0] == '1)); // R9
  AST_AUTOEOI_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ackStb && irqOut && autoEoi && !eoiValid |=> (svcRegOut == $past(svcRegOut))); // R8
endmodule

// File: tb/sim_intr_prio_core.sv
`timescale 1ns/1ps
module sim_intr_prio_core;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] raiseStb, dropStb, enableMask, levelSel, vectorBase;
  logic       autoEoi, specialMask, eoiValid, eoiSpecific, ackStb;
  logic [2:0] eoiLine;
  logic       irqOut;
  logic [7:0] vectorOut, reqRegOut, svcRegOut;
  int         nChecks = 0;
  int         nErrors = 0;

  always #5 clk = ~clk;

  intr_prio_core u0 (
    .clk(clk), .rstN(rstN), .raiseStb(raiseStb), .dropStb(dropStb),
    .enableMask(enableMask), .levelSel(levelSel), .autoEoi(autoEoi),
    .specialMask(specialMask), .eoiValid(eoiValid), .eoiSpecific(eoiSpecific),
    .eoiLine(eoiLine), .vectorBase(vectorBase), .ackStb(ackStb),
    .irqOut(irqOut), .vectorOut(vectorOut), .reqRegOut(reqRegOut),
    .svcRegOut(svcRegOut)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nErrors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; raiseStb = '0; dropStb = '0; enableMask = 8'hFF;
    levelSel = '0; autoEoi = 0; specialMask = 0; eoiValid = 0;
    eoiSpecific = 0; eoiLine = '0; vectorBase = 8'h40; ackStb = 0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic raise(input logic [7:0] m);
    raiseStb = m; tick(); raiseStb = '0;
  endtask
  task automatic drop(input logic [7:0] m);
    dropStb = m; tick(); dropStb = '0;
  endtask
  task automatic ack();
    ackStb = 1; tick(); ackStb = 0;
  endtask
  task automatic eoi(input logic spec, input logic [2:0] ln);
    eoiValid = 1; eoiSpecific = spec; eoiLine = ln; tick(); eoiValid = 0;
  endtask

  initial begin
    #2000000;
    nErrors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; raiseStb = '0; dropStb = '0; enableMask = 8'hFF;
    levelSel = '0; autoEoi = 0; specialMask = 0; eoiValid = 0;
    eoiSpecific = 0; eoiLine = '0; vectorBase = 8'h40; ackStb = 0;
    tick(); tick();
    // R1 reset state
    chk("R1 irq", irqOut, 0); chk("R1 req", reqRegOut, 0);
    chk("R1 svc", svcRegOut, 0); chk("R1 vec", vectorOut, 0);

    // Single-line sweep
    for (int i = 0; i < 8; i++) begin
      doReset();
      vectorBase = 8'h80 | 8'(i << 4);
      raise(8'(1 << i));
      chk("R2 req set", reqRegOut, 1 << i);
      tick();
      chk("R2 irq", irqOut, 1);
      ack();
      chk("R6 vector", vectorOut, (8'h80 | (i << 4)) | i);
      chk("R6 irq drop", irqOut, 0);
      chk("R7 edge clear", reqRegOut, 0);
      chk("R8 svc set", svcRegOut, 1 << i);
      eoi(1, 3'(i));
      chk("R11 specific", svcRegOut, 0);
      raise(8'(1 << i));
      chk("R10 latched raise", reqRegOut, 0);
      drop(8'(1 << i));
      raise(8'(1 << i));
      chk("R10 raise after drop", reqRegOut, 1 << i);
      drop(8'(1 << i));
      chk("R10 drop clears", reqRegOut, 0);
    end

    // Pair sweep: priority and blocking
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        doReset();
        raise(8'((1 << i) | (1 << j)));
        tick();
        chk("R2 irq pair", irqOut, 1);
        ack();
        chk("R3 winner", vectorOut, 8'h40 | i);
        chk("R7 loser kept", reqRegOut, 1 << j);
        tick(); tick();
        chk("R4 blocked", irqOut, 0);
        eoi(0, 3'd0);
        chk("R11 nonspecific", svcRegOut, 0);
        tick();
        chk("R4 released", irqOut, 1);
        ack();
        chk("R3 second", vectorOut, 8'h40 | j);
      end
    end

    // Disabled line
    doReset();
    enableMask = 8'hF7;
    raise(8'h08); tick(); tick();
    chk("R3 disabled", irqOut, 0);
    enableMask = 8'hFF;
    tick();
    chk("R3 enabled", irqOut, 1);

    // Special mask mode
    doReset();
    raise(8'h04); tick(); ack();
    chk("R8 svc2", svcRegOut, 8'h04);
    raise(8'h20); tick(); tick();
    chk("R4 lower blocked", irqOut, 0);
    enableMask = 8'hFB; tick(); tick();
    chk("R5 off no effect", irqOut, 0);
    specialMask = 1; tick();
    chk("R5 special unblocks", irqOut, 1);
    ack();
    chk("R5 vector", vectorOut, 8'h45);
    chk("R5 svc both", svcRegOut, 8'h24);

    // Level mode, equal-priority blocking, auto EOI
    doReset();
    levelSel = 8'h02;
    raise(8'h02); tick(); ack();
    chk("R7 level kept", reqRegOut, 8'h02);
    tick(); tick();
    chk("R4 equal blocked", irqOut, 0);
    eoi(0, 3'd0);
    autoEoi = 1;
    tick();
    chk("R4 reassert", irqOut, 1);
    ack();
    chk("R8 autoEoi svc", svcRegOut, 0);
    chk("R7 level kept 2", reqRegOut, 8'h02);
    tick();
    chk("R8 autoEoi reissue", irqOut, 1);

    // Spurious and hold behaviour
    doReset();
    raise(8'h10); tick();
    chk("R12 irq up", irqOut, 1);
    tick();
    chk("R12 irq held", irqOut, 1);
    drop(8'h10);
    chk("R12 held one edge", irqOut, 1);
    ack();
    chk("R9 spurious vec", vectorOut, 8'h47);
    chk("R9 svc untouched", svcRegOut, 0);
    chk("R9 irq", irqOut, 0);
    ack();
    chk("R12 ack ignored", vectorOut, 8'h47);
    raise(8'h10); tick();
    drop(8'h10); tick();
    chk("R12 empty drops", irqOut, 0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule